// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the arbitration core of an eight-line interrupt controller. Each request line is captured into a pending register. A per-line mode input selects whether a line is level sensitive or edge sensitive. A mask input hides pending lines from arbitration. An in-service register records the lines the processor has accepted and not yet retired.

The winner is the unmasked pending line nearest to a 3-bit rotation base, counted upward with wrap-around. The block raises its request only when that winner ranks strictly above every line in service, so nested interrupts work. A command decoder outside the block drives the retire and rotation commands. Retirement can also happen automatically at acknowledge time, and in that case it can move the rotation base.

The search is combinational. Every register updates on one rising clock edge, and reset is synchronous.

Top module: `irq_resolver`

## Requirements
- R1: A line whose `trig_level_i` bit is 1 has a pending bit equal to its request level from the previous clock edge. The bit sets when the line is high and clears when it is low.
- R2: A line whose `trig_level_i` bit is 0 sets its pending bit when it is sampled high after being sampled low. Lowering the line afterwards leaves the pending bit set.
- R3: Rank is (line − base) mod 8, and the smallest rank wins. After reset the base is 0. `irq_line_o` gives the winning line.
- R4: `irq_o` is 1 only when the best unmasked pending rank is strictly smaller than the best in-service rank. An empty in-service set ranks 8.
- R5: `ack_i` while `irq_o` is 1 is an acknowledge. With `auto_eoi_i`=0 it sets the in-service bit of the winning line. With `auto_eoi_i`=1 the in-service bit stays clear, and if `rot_on_aeoi_i`=1 the base becomes winner+1 mod 8.
- R6: An acknowledge clears the winner's pending bit only on an edge-sensitive line. A level-sensitive pending bit stays set.
- R7: Command code 1 (`cmd_valid_i`=1, `cmd_op_i`=1) clears the best-ranked in-service bit. Code 2 also sets the base to that line+1.
- R8: Code 3 clears the in-service bit of line `cmd_line_i`. Code 5 also sets the base to that line+1. Code 4 sets the base to `cmd_line_i`+1. Codes 0, 6 and 7 do nothing.
- R9: A line whose `mask_i` bit is 1 never wins and never raises `irq_o`, but its pending bit is kept.
- R10: If an acknowledge and a new rising edge hit the same edge-sensitive line in one cycle, the pending bit stays set.
- R11: Synchronous reset clears the pending, in-service, sampled-level and base state, so `irq_o` is 0 in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 8 | Request lines |
| trig_level_i | input | 8 | Per-line mode, 1 = level, 0 = edge |
| mask_i | input | 8 | Per-line mask, 1 = hidden |
| ack_i | input | 1 | Acknowledge strobe |
| auto_eoi_i | input | 1 | Retire automatically on acknowledge |
| rot_on_aeoi_i | input | 1 | Rotate base on automatic retire |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_line_i | input | 3 | Line operand of the command |
| irq_o | output | 1 | Interrupt request |
| irq_line_o | output | 3 | Winning line number |

## Verification
The bench targets the following corner cases, with the fault each one would expose:

- **Equal rank.** A pending line whose rank equals the in-service rank must not request. A design that compares with less-or-equal would re-raise a line that is already in service.
- **Rotation.** The winner is checked after a rotating end-of-interrupt, after a set-base command and after auto-EOI rotation. An off-by-one base or an unrotated search would pick the wrong line.
- **Level lines.** A level-sensitive line is dropped, raised again and acknowledged. A design that cleared it on acknowledge or latched it like an edge would drop the request or keep it after the line falls.
- **Acknowledge with a new edge.** An acknowledge that meets a new edge on the same line must leave the request pending. A design that let the clear win would lose that interrupt.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

    typedef enum logic [2:0] {
        CMD_NONE         = 3'd0,
        CMD_EOI_BEST     = 3'd1,
        CMD_EOI_BEST_ROT = 3'd2,
        CMD_EOI_LINE     = 3'd3,
        CMD_SET_BASE     = 3'd4,
        CMD_EOI_LINE_ROT = 3'd5
    } cmd_e;

endpackage

// File: rtl/irqr_rank_find.sv
// Rotating search: returns the set bit with the smallest (index - base) mod N.
module irqr_rank_find #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] vec_i,
    input  logic [W-1:0] base_i,
    output logic         found_o,
    output logic [W-1:0] line_o,
    output logic [W:0]   rank_o
);
    always_comb begin
        found_o = 1'b0;
        line_o  = '0;
        rank_o  = (W+1)'(N);
        for (int k = N - 1; k >= 0; k--) begin
            int idx;
            idx = (k + int'(base_i)) % N;
            if (vec_i[idx]) begin
                found_o = 1'b1;
                line_o  = W'(idx);
                rank_o  = (W+1)'(k);
            end
        end
    end
endmodule

// File: rtl/irqr_capture.sv
// Per-line pending capture: level lines track the input, edge lines latch rises.
module irqr_capture #(
    parameter int N = 8
) (
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] last_i,
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] level_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic rise;
        assign rise = req_i[g] & ~last_i[g];
        // a fresh rise overrides an acknowledge clear in the same cycle
        assign pend_o[g] = level_i[g] ? req_i[g]
                                      : ((pend_i[g] & ~clr_i[g]) | rise);
    end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irqr_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int LW = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req_i,
    input  logic [NUM_LINES-1:0] trig_level_i,
    input  logic [NUM_LINES-1:0] mask_i,
    input  logic                 ack_i,
    input  logic                 auto_eoi_i,
    input  logic                 rot_on_aeoi_i,
    input  logic                 cmd_valid_i,
    input  logic [2:0]           cmd_op_i,
    input  logic [LW-1:0]        cmd_line_i,
    output logic                 irq_o,
    output logic [LW-1:0]        irq_line_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] last;
        logic [NUM_LINES-1:0] isr;
        logic [LW-1:0]        base;
    } state_t;

    state_t st_d, st_q;

    function automatic logic [LW-1:0] next_line(input logic [LW-1:0] l);
        return LW'((int'(l) + 1) % NUM_LINES);
    endfunction

    // ranking of requests and of lines in service
    logic          p_found, s_found;
    logic [LW-1:0] p_line, s_line;
    logic [LW:0]   p_rank, s_rank;

    irqr_rank_find #(.N(NUM_LINES)) i_pend_find (
        .vec_i  (st_q.pend & ~mask_i),
        .base_i (st_q.base),
        .found_o(p_found),
        .line_o (p_line),
        .rank_o (p_rank)
    );

    irqr_rank_find #(.N(NUM_LINES)) i_isr_find (
        .vec_i  (st_q.isr),
        .base_i (st_q.base),
        .found_o(s_found),
        .line_o (s_line),
        .rank_o (s_rank)
    );

    assign irq_o      = p_found && (p_rank < s_rank);
    assign irq_line_o = p_line;

    logic                 ack_take;
    logic [NUM_LINES-1:0] ack_vec;
    logic [NUM_LINES-1:0] pend_cap;

    assign ack_take = ack_i & irq_o;
    assign ack_vec  = ack_take ? (NUM_LINES'(1) << p_line) : '0;

    irqr_capture #(.N(NUM_LINES)) i_capture (
        .req_i  (req_i),
        .last_i (st_q.last),
        .pend_i (st_q.pend),
        .level_i(trig_level_i),
        .clr_i  (ack_vec & ~trig_level_i),
        .pend_o (pend_cap)
    );

    always_comb begin
        st_d      = st_q;
        st_d.last = req_i;
        st_d.pend = pend_cap;
        if (ack_take) begin
            if (!auto_eoi_i) begin
                st_d.isr[p_line] = 1'b1;
            end else if (rot_on_aeoi_i) begin
                st_d.base = next_line(p_line);
            end
        end
        // commands are applied after the acknowledge and take precedence
        if (cmd_valid_i) begin
            unique case (cmd_op_i)
                CMD_EOI_BEST, CMD_EOI_BEST_ROT: begin
                    if (s_found) begin
                        st_d.isr[s_line] = 1'b0;
                        if (cmd_op_i == CMD_EOI_BEST_ROT) begin
                            st_d.base = next_line(s_line);
                        end
                    end
                end
                CMD_EOI_LINE: st_d.isr[cmd_line_i] = 1'b0;
                CMD_EOI_LINE_ROT: begin
                    st_d.isr[cmd_line_i] = 1'b0;
                    st_d.base = next_line(cmd_line_i);
                end
                CMD_SET_BASE: st_d.base = next_line(cmd_line_i);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // one cycle of history exists after reset
    logic hist_q;
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= 1'b1;
    end

    p_level_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hist_q |-> (((st_q.pend ^ $past(req_i)) & $past(trig_level_i)) == '0));

    p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_q && !$past(ack_i)) |->
            (($past(st_q.pend) & ~$past(trig_level_i) & ~st_q.pend) == '0));

    p_req_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (st_q.pend[irq_line_o] && !mask_i[irq_line_o]));

    p_no_reentry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !st_q.isr[irq_line_o]);

    p_ack_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !auto_eoi_i && !cmd_valid_i) |=>
            st_q.isr[$past(irq_line_o)]);

    p_eoi_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_op_i == CMD_EOI_BEST && st_q.isr != '0 && !ack_i) |=>
            ($countones(st_q.isr) + 1 == $countones($past(st_q.isr))));

endmodule

// File: tb/test_irq_resolver.sv
module test_irq_resolver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0, lvl = '0, msk = '0;
    logic       ack = 1'b0, aeoi = 1'b0, rot = 1'b0, cv = 1'b0;
    logic [2:0] op = '0, ln = '0;
    logic       irq;
    logic [2:0] irq_line;
    int         n_run = 0, n_fail = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    irq_resolver i_irq_resolver (
        .clk(clk), .rst_n(rst_n), .req_i(req), .trig_level_i(lvl), .mask_i(msk),
        .ack_i(ack), .auto_eoi_i(aeoi), .rot_on_aeoi_i(rot), .cmd_valid_i(cv),
        .cmd_op_i(op), .cmd_line_i(ln), .irq_o(irq), .irq_line_o(irq_line)
    );

    typedef struct packed {
        logic [7:0] req, lvl, msk;
        logic       ack, cv;
        logic [2:0] op, ln;
        logic       eirq;
        logic [2:0] eline;
        logic [7:0] tag;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 8'd11}, // R11 idle
        '{8'h08, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd3, 8'd2},  // R2 edge sets
        '{8'h08, 8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 8'd5},  // R5 ack, R6 edge cleared
        '{8'h28, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 8'd4},  // R4 lower rank blocked
        '{8'h29, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd0, 8'd4},  // R4 higher preempts
        '{8'h29, 8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 8'd5},  // R5 nested ack
        '{8'h29, 8'h00, 8'h00, 1'b0, 1'b1, 3'd1, 3'd0, 1'b0, 3'd0, 8'd7},  // R7 retire line 0
        '{8'h29, 8'h00, 8'h00, 1'b0, 1'b1, 3'd2, 3'd0, 1'b1, 3'd5, 8'd7},  // R7 retire 3, base 4
        '{8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd5, 8'd2},  // R2 drop keeps pending
        '{8'h00, 8'h00, 8'h20, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 8'd9},  // R9 masked
        '{8'h02, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd5, 8'd3},  // R3 base 4: 5 beats 1
        '{8'h02, 8'h00, 8'h00, 1'b0, 1'b1, 3'd4, 3'd0, 1'b1, 3'd1, 8'd8},  // R8 base 1: 1 wins
        '{8'h02, 8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 8'd4},  // R4 line 5 below isr 1
        '{8'h02, 8'h00, 8'h00, 1'b0, 1'b1, 3'd3, 3'd1, 1'b1, 3'd5, 8'd8},  // R8 specific retire
        '{8'h80, 8'h80, 8'h20, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd7, 8'd1},  // R1 level high
        '{8'h00, 8'h80, 8'h20, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 8'd1},  // R1 level low clears
        '{8'h80, 8'h80, 8'h20, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd7, 8'd1},  // R1 level again
        '{8'h80, 8'h80, 8'h20, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 8'd6},  // R6 ack level line
        '{8'h80, 8'h80, 8'h20, 1'b0, 1'b1, 3'd3, 3'd7, 1'b1, 3'd7, 8'd6}   // R6 level still pending
    };

    task automatic check(input logic eirq, input logic [2:0] eline, input int tag);
        n_run++;
        if (irq !== eirq || (eirq && irq_line !== eline)) begin
            n_fail++;
            $display("FAIL R%0d: irq=%0b line=%0d expected irq=%0b line=%0d",
                     tag, irq, irq_line, eirq, eline);
        end
    endtask

    task automatic idle_inputs();
        ack = 0; cv = 0; op = 0; ln = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; req = 0; lvl = 0; msk = 0; aeoi = 0; rot = 0;
        idle_inputs();
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        // R11: reset with all lines high
        @(negedge clk);
        req = 8'hFF;
        repeat (2) @(negedge clk);
        check(1'b0, 3'd0, 11); // R11 irq low during reset
        req = 8'h00;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(1'b0, 3'd0, 11); // R11 clean start

        for (int i = 0; i < NV; i++) begin
            req = TBL[i].req; lvl = TBL[i].lvl; msk = TBL[i].msk;
            ack = TBL[i].ack; cv = TBL[i].cv; op = TBL[i].op; ln = TBL[i].ln;
            @(negedge clk);
            check(TBL[i].eirq, TBL[i].eline, int'(TBL[i].tag));
        end

        // R5: auto-EOI with rotation
        do_reset();
        aeoi = 1; rot = 1; req = 8'h04;
        @(negedge clk);
        check(1'b1, 3'd2, 5);
        ack = 1;
        @(negedge clk);
        check(1'b0, 3'd0, 5);
        ack = 0; req = 8'h15;
        @(negedge clk);
        check(1'b1, 3'd4, 5); // R5 base 3, no in-service
        ack = 1;
        @(negedge clk);
        check(1'b1, 3'd0, 3); // R3 base 5 next winner
        ack = 0;

        // R10: acknowledge meets a new edge on the same line
        do_reset();
        req = 8'h40;
        @(negedge clk);
        req = 8'h00;
        @(negedge clk);
        check(1'b1, 3'd6, 2);
        req = 8'h40; ack = 1;
        @(negedge clk);
        check(1'b0, 3'd0, 10); // R10 equal rank blocked
        ack = 0; cv = 1; op = 3'd3; ln = 3'd6;
        @(negedge clk);
        check(1'b1, 3'd6, 10); // R10 pending survived
        idle_inputs();

        // R8: unused codes do nothing, rotating specific retire
        req = 8'h40; ack = 1;
        @(negedge clk);
        ack = 0; cv = 1; op = 3'd7; ln = 3'd6;
        @(negedge clk);
        check(1'b0, 3'd0, 8); // R8 code 7 is a no-op
        req = 8'h00; op = 3'd5; ln = 3'd6;
        @(negedge clk);
        idle_inputs();
        req = 8'h41;
        @(negedge clk);
        check(1'b1, 3'd0, 8); // R8 base 7: 0 beats 6 (pending 6 still set)

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL R11: watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule